// File: doc/BRIEF.md
# Tearing-Effect Frame Trigger

This block decides when a frame transfer to a display panel may begin. A panel with its own frame memory signals its refresh position on a tearing-effect (TE) line. The block filters that line and tells vertical sync from line pulses by how long each pulse stays active. After a vertical sync it counts line pulses. When the count reaches a programmed line number and a transfer has been requested, it emits a one-cycle start strobe. A second operating style takes vertical sync from a separate input and treats every qualified pulse on the TE line as a line pulse.

When TE use is switched off, or the internal-trigger mode is selected, a transfer request gives a start strobe on the next cycle without waiting for the panel. The programmed widths, mode and line number are checked at all times. A configuration that the panel timing rules forbid raises an error flag, and no TE-driven start is issued while the flag is set.

Top module: `te_frame_trigger`

## Requirements
- R1: With `te_en_i` low, or `mode_i` = 0 (internal trigger), a high `req_i` sampled on a clock edge makes `start_o` high for exactly the following cycle.
- R2: With TE active (`te_en_i` high and `mode_i` not 0), `cfg_err_o` is high when `hs_width_i` is below 2.
- R3: With TE active, `cfg_err_o` is high when `vs_width_i` is below 4 in mode 1 (`mode_i` = 1) or below 2 in mode 2 (`mode_i` = 2). Values at or above these limits pass this rule.
- R4: With TE active, `cfg_err_o` is high when `vs_width_i` equals `hs_width_i`.
- R5: With TE active, `cfg_err_o` is high when `line_i` exceeds 2047. A value of 2047 is accepted.
- R6: In mode 1, a TE pulse whose active width in clock cycles is at least `vs_width_i` is a vertical sync and resets the line count to 0. A shorter pulse of at least `hs_width_i` cycles adds one line. A pending request produces one start when the count reaches `line_i`.
- R7: In mode 2, vertical sync is a pulse of at least `vs_width_i` cycles on `vsync_i`. Every TE pulse of at least `hs_width_i` cycles is a line pulse, however long it is.
- R8: A TE pulse shorter than `hs_width_i` cycles does not change the line count.
- R9: A frame gives at most one start. A request is used up by the start it produces. A frame that reaches the programmed line with no pending request gives no start.
- R10: The active level of `te_i` follows `vs_pol_i` in mode 1 and `hs_pol_i` in mode 2. The active level of `vsync_i` follows `vs_pol_i`. A polarity bit of 1 means active high and 0 means active low.
- R11: While `cfg_err_o` is high in a TE mode, `start_o` stays low and a pending request is kept for a later valid frame.
- R12: With `te_en_i` high, `mode_i` = 3 is rejected through `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | Raw tearing-effect pin from the panel |
| vsync_i | input | 1 | Separate vertical sync input, used in mode 2 |
| te_en_i | input | 1 | Enable TE-driven triggering |
| mode_i | input | 2 | 0 internal, 1 shared-line TE, 2 separate-vsync TE, 3 invalid |
| hs_width_i | input | CNT_W | Minimum line-pulse width in cycles |
| vs_width_i | input | CNT_W | Minimum vertical-sync width in cycles |
| hs_pol_i | input | 1 | Line-pulse polarity, 1 = active high |
| vs_pol_i | input | 1 | Vertical-sync polarity, 1 = active high |
| line_i | input | LINE_IN_W | Line number at which to trigger |
| req_i | input | 1 | Transfer request |
| start_o | output | 1 | One-cycle transfer start strobe |
| cfg_err_o | output | 1 | Configuration rejected |

## Verification
The hardest case to reach is a vertical sync that lands in the middle of a frame whose line count is already partly advanced. The pulse must be exactly `vs_width_i` cycles long, so it sits on the boundary between the two pulse classes. The stimulus drives a long vertical sync and two line pulses, then a pulse of exactly the vertical width. It then shows that three more line pulses, not one, are needed before the start appears. Glitches one cycle under the line minimum are placed between valid lines to show that they do not advance the count.

// File: rtl/tet_pkg.sv
package tet_pkg;
  typedef enum logic [1:0] {
    TRIG_INT = 2'd0,
    TRIG_TE1 = 2'd1,
    TRIG_TE2 = 2'd2,
    TRIG_BAD = 2'd3
  } trig_mode_e;

  localparam int unsigned HS_MIN     = 2;
  localparam int unsigned VS_MIN_TE1 = 4;
  localparam int unsigned VS_MIN_TE2 = 2;
endpackage

// File: rtl/tet_pulse_meas.sv
module tet_pulse_meas #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             act_high_i,
  output logic             end_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   act, act_q;
  logic [CNT_W-1:0]       cnt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  assign act = act_high_i ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act;
      if (!act)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // width is still held in the cycle the pulse ends
  assign end_o   = act_q & ~act;
  assign width_o = cnt_q;
endmodule

// File: rtl/tet_cfg_check.sv
module tet_cfg_check
  import tet_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LINE_W    = 11,
  parameter int unsigned LINE_IN_W = 16
) (
  input  logic                 te_on_i,
  input  trig_mode_e           mode_i,
  input  logic [CNT_W-1:0]     hs_width_i,
  input  logic [CNT_W-1:0]     vs_width_i,
  input  logic [LINE_IN_W-1:0] line_i,
  output logic                 err_o
);
  logic [CNT_W-1:0] vs_min;
  logic             line_hi;

  assign vs_min  = (mode_i == TRIG_TE2) ? CNT_W'(VS_MIN_TE2) : CNT_W'(VS_MIN_TE1);
  assign line_hi = |(line_i >> LINE_W);

  always_comb begin
    err_o = 1'b0;
    if (te_on_i) begin
      if (mode_i == TRIG_BAD)             err_o = 1'b1;
      if (hs_width_i < CNT_W'(HS_MIN))    err_o = 1'b1;
      if (vs_width_i < vs_min)            err_o = 1'b1;
      if (vs_width_i == hs_width_i)       err_o = 1'b1;
      if (line_hi)                        err_o = 1'b1;
    end
  end
endmodule

// File: rtl/tet_line_track.sv
module tet_line_track
  import tet_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LINE_W    = 11,
  parameter int unsigned LINE_IN_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 te_on_i,
  input  trig_mode_e           mode_i,
  input  logic                 te_end_i,
  input  logic [CNT_W-1:0]     te_width_i,
  input  logic                 vs_end_i,
  input  logic [CNT_W-1:0]     vs_width_i,
  input  logic [CNT_W-1:0]     hs_min_i,
  input  logic [CNT_W-1:0]     vs_min_i,
  input  logic [LINE_IN_W-1:0] line_i,
  output logic                 hit_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic              vs_c, hs_c, vs_ev_q, hs_ev_q;
  logic              armed_q, hit_q;
  logic [LINE_W-1:0] cnt_q, cnt_nxt, tgt;

  assign tgt = line_i[LINE_W-1:0];

  always_comb begin
    vs_c = 1'b0;
    hs_c = 1'b0;
    unique case (mode_i)
      TRIG_TE1: begin
        vs_c = te_end_i & (te_width_i >= vs_min_i);
        hs_c = te_end_i & (te_width_i <  vs_min_i) & (te_width_i >= hs_min_i);
      end
      TRIG_TE2: begin
        vs_c = vs_end_i & (vs_width_i >= vs_min_i);
        hs_c = te_end_i & (te_width_i >= hs_min_i);
      end
      default: ;
    endcase
  end

  assign cnt_nxt = (cnt_q == LINE_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_ev_q <= 1'b0;
      hs_ev_q <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      vs_ev_q <= te_on_i & vs_c;
      hs_ev_q <= te_on_i & hs_c;
      hit_q   <= 1'b0;
      if (!te_on_i) begin
        armed_q <= 1'b0;
      end else if (vs_ev_q) begin
        cnt_q   <= '0;
        armed_q <= (tgt != '0);
        hit_q   <= (tgt == '0);
      end else if (hs_ev_q && armed_q) begin
        cnt_q <= cnt_nxt;
        if (cnt_q != LINE_MAX && cnt_nxt == tgt) begin
          hit_q   <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/tet_start_ctl.sv
module tet_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_mode_i,
  input  logic err_i,
  input  logic req_i,
  input  logic hit_i,
  output logic start_o
);
  logic pend_q, start_q, fire;

  assign fire = hit_i & ~err_i & (pend_q | req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (int_mode_i) begin
      pend_q  <= 1'b0;
      start_q <= req_i;
    end else begin
      start_q <= fire;
      pend_q  <= fire ? 1'b0 : (pend_q | req_i);
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/te_frame_trigger.sv
module te_frame_trigger
  import tet_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LINE_W      = 11,
  parameter int unsigned LINE_IN_W   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 te_i,
  input  logic                 vsync_i,
  input  logic                 te_en_i,
  input  logic [1:0]           mode_i,
  input  logic [CNT_W-1:0]     hs_width_i,
  input  logic [CNT_W-1:0]     vs_width_i,
  input  logic                 hs_pol_i,
  input  logic                 vs_pol_i,
  input  logic [LINE_IN_W-1:0] line_i,
  input  logic                 req_i,
  output logic                 start_o,
  output logic                 cfg_err_o
);
  trig_mode_e       mode;
  logic             te_on, te_pol;
  logic             te_end, vs_end, hit;
  logic [CNT_W-1:0] te_w, vs_w;

  assign mode   = trig_mode_e'(mode_i);
  assign te_on  = te_en_i & (mode != TRIG_INT);
  assign te_pol = (mode == TRIG_TE2) ? hs_pol_i : vs_pol_i;

  tet_pulse_meas #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_te_meas (
    .clk_i, .rst_ni, .pin_i(te_i), .act_high_i(te_pol),
    .end_o(te_end), .width_o(te_w)
  );

  tet_pulse_meas #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_vs_meas (
    .clk_i, .rst_ni, .pin_i(vsync_i), .act_high_i(vs_pol_i),
    .end_o(vs_end), .width_o(vs_w)
  );

  tet_cfg_check #(.CNT_W(CNT_W), .LINE_W(LINE_W), .LINE_IN_W(LINE_IN_W)) u_cfg (
    .te_on_i(te_on), .mode_i(mode), .hs_width_i, .vs_width_i, .line_i,
    .err_o(cfg_err_o)
  );

  tet_line_track #(.CNT_W(CNT_W), .LINE_W(LINE_W), .LINE_IN_W(LINE_IN_W)) u_lines (
    .clk_i, .rst_ni, .te_on_i(te_on), .mode_i(mode),
    .te_end_i(te_end), .te_width_i(te_w),
    .vs_end_i(vs_end), .vs_width_i(vs_w),
    .hs_min_i(hs_width_i), .vs_min_i(vs_width_i),
    .line_i, .hit_o(hit)
  );

  tet_start_ctl u_start (
    .clk_i, .rst_ni, .int_mode_i(~te_on), .err_i(cfg_err_o),
    .req_i, .hit_i(hit), .start_o
  );
endmodule

// File: rtl/te_frame_trigger_chk.sv
module te_frame_trigger_chk #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LINE_W    = 11,
  parameter int unsigned LINE_IN_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 te_en_i,
  input logic [1:0]           mode_i,
  input logic [CNT_W-1:0]     hs_width_i,
  input logic [CNT_W-1:0]     vs_width_i,
  input logic [LINE_IN_W-1:0] line_i,
  input logic                 req_i,
  input logic                 start_o,
  input logic                 cfg_err_o
);
  logic te_on;
  assign te_on = te_en_i & (mode_i != 2'd0);

  // R1
  int_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te_on && req_i) |=> start_o);

  // R9
  single_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && te_on) |=> !start_o);

  // R11
  err_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && te_on && $past(te_on)) |-> $past(!cfg_err_o));

  // R2
  hs_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_on && hs_width_i < CNT_W'(2)) |-> cfg_err_o);

  // R4
  width_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_on && hs_width_i == vs_width_i) |-> cfg_err_o);

  // R5
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_on && (line_i >> LINE_W) != '0) |-> cfg_err_o);
endmodule

bind te_frame_trigger te_frame_trigger_chk #(
  .CNT_W(CNT_W), .LINE_W(LINE_W), .LINE_IN_W(LINE_IN_W)
) u_chk (.*);

// File: tb/te_frame_trigger_tb_top.sv
module te_frame_trigger_tb_top;
  localparam int CNT_W = 8;
  localparam int LINE_IN_W = 16;
  localparam int NCFG = 11;

  // {mode, hs, vs, line, err}
  localparam logic [34:0] CFG_TAB [NCFG] = '{
    {2'd1, 8'd3, 8'd6, 16'd5,    1'b0},  // R3 mode 1 nominal
    {2'd1, 8'd1, 8'd6, 16'd5,    1'b1},  // R2
    {2'd1, 8'd2, 8'd4, 16'd5,    1'b0},  // R3 mode 1 boundary
    {2'd1, 8'd2, 8'd3, 16'd5,    1'b1},  // R3
    {2'd2, 8'd3, 8'd2, 16'd5,    1'b0},  // R3 mode 2 boundary
    {2'd2, 8'd3, 8'd1, 16'd5,    1'b1},  // R3
    {2'd2, 8'd4, 8'd4, 16'd5,    1'b1},  // R4
    {2'd1, 8'd3, 8'd6, 16'd2047, 1'b0},  // R5 top value
    {2'd1, 8'd3, 8'd6, 16'd2048, 1'b1},  // R5
    {2'd3, 8'd3, 8'd6, 16'd5,    1'b1},  // R12
    {2'd0, 8'd0, 8'd0, 16'd0,    1'b0}   // R1 internal: no validation
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 te_i, vsync_i, te_en, hs_pol, vs_pol, req;
  logic [1:0]           mode;
  logic [CNT_W-1:0]     hs_w, vs_w;
  logic [LINE_IN_W-1:0] line;
  logic                 start_o, cfg_err_o;

  int  checks = 0;
  int  errors = 0;
  int  starts = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  te_frame_trigger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .te_i(te_i), .vsync_i(vsync_i),
    .te_en_i(te_en), .mode_i(mode), .hs_width_i(hs_w), .vs_width_i(vs_w),
    .hs_pol_i(hs_pol), .vs_pol_i(vs_pol), .line_i(line), .req_i(req),
    .start_o(start_o), .cfg_err_o(cfg_err_o)
  );

  always @(negedge clk) if (rst_n && start_o) starts++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input int h, input int v, input int l, input bit en);
    mode = m; hs_w = CNT_W'(h); vs_w = CNT_W'(v); line = LINE_IN_W'(l); te_en = en;
    @(negedge clk);
  endtask

  task automatic te_pulse(input int w, input bit act_lvl);
    te_i = act_lvl;
    repeat (w) @(negedge clk);
    te_i = ~act_lvl;
    repeat (8) @(negedge clk);
  endtask

  task automatic vs_pulse(input int w);
    vsync_i = 1'b1;
    repeat (w) @(negedge clk);
    vsync_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic request();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    rst_n = 1'b0; te_i = 1'b0; vsync_i = 1'b0; te_en = 1'b0; hs_pol = 1'b1;
    vs_pol = 1'b1; req = 1'b0; mode = 2'd1; hs_w = 8'd3; vs_w = 8'd6; line = 16'd3;
    repeat (3) @(negedge clk);
    chk(start_o == 1'b0, "R1 reset start", start_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // configuration table
    for (int i = 0; i < NCFG; i++) begin
      logic [1:0] m; logic [7:0] h, v; logic [15:0] l; logic e;
      {m, h, v, l, e} = CFG_TAB[i];
      cfg(m, h, v, l, 1'b1);
      chk(cfg_err_o == e, "config table R2 R3 R4 R5 R12", cfg_err_o, e);
    end

    // R1: TE disabled -> next-cycle start, single cycle
    cfg(2'd1, 3, 6, 3, 1'b0);
    req = 1'b1; @(negedge clk); req = 1'b0;
    chk(start_o == 1'b1, "R1 internal start", start_o, 1);
    @(negedge clk);
    chk(start_o == 1'b0, "R1 strobe width", start_o, 0);
    // R1: mode 0 with enable set
    cfg(2'd0, 3, 6, 3, 1'b1);
    req = 1'b1; @(negedge clk); req = 1'b0;
    chk(start_o == 1'b1, "R1 mode 0 start", start_o, 1);

    // R6 / R9: mode 1, line 3
    cfg(2'd1, 3, 6, 3, 1'b1);
    repeat (4) @(negedge clk);
    s0 = starts;
    request();
    chk(starts == s0, "R6 no start before frame", starts - s0, 0);
    te_pulse(8, 1'b1);
    te_pulse(4, 1'b1);
    te_pulse(4, 1'b1);
    chk(starts == s0, "R6 early lines", starts - s0, 0);
    te_pulse(4, 1'b1);
    chk(starts == s0 + 1, "R6 trigger at line", starts - s0, 1);
    te_pulse(4, 1'b1);
    te_pulse(4, 1'b1);
    chk(starts == s0 + 1, "R9 once per frame", starts - s0, 1);
    te_pulse(8, 1'b1);
    repeat (3) te_pulse(4, 1'b1);
    chk(starts == s0 + 1, "R9 request consumed", starts - s0, 1);

    // R6: vsync of exactly vs width mid-frame restarts the count
    s0 = starts;
    request();
    te_pulse(8, 1'b1);
    te_pulse(4, 1'b1);
    te_pulse(4, 1'b1);
    te_pulse(6, 1'b1);
    te_pulse(4, 1'b1);
    te_pulse(4, 1'b1);
    chk(starts == s0, "R6 boundary vsync resets count", starts - s0, 0);
    te_pulse(4, 1'b1);
    chk(starts == s0 + 1, "R6 trigger after restart", starts - s0, 1);

    // R8: glitches ignored
    s0 = starts;
    request();
    te_pulse(8, 1'b1);
    te_pulse(4, 1'b1);
    te_pulse(2, 1'b1);
    te_pulse(4, 1'b1);
    te_pulse(2, 1'b1);
    chk(starts == s0, "R8 glitches not counted", starts - s0, 0);
    te_pulse(3, 1'b1);
    chk(starts == s0 + 1, "R8 line at hs width counts", starts - s0, 1);

    // R10: mode 1 active-low TE
    vs_pol = 1'b0; te_i = 1'b1;
    repeat (6) @(negedge clk);
    s0 = starts;
    request();
    te_pulse(8, 1'b0);
    repeat (3) te_pulse(4, 1'b0);
    chk(starts == s0 + 1, "R10 active-low TE", starts - s0, 1);
    vs_pol = 1'b1; te_i = 1'b0;
    repeat (6) @(negedge clk);

    // R7: mode 2, vsync on own input, long TE pulse is a line
    cfg(2'd2, 3, 2, 2, 1'b1);
    repeat (4) @(negedge clk);
    s0 = starts;
    request();
    vs_pulse(3);
    te_pulse(8, 1'b1);
    chk(starts == s0, "R7 one line", starts - s0, 0);
    te_pulse(3, 1'b1);
    chk(starts == s0 + 1, "R7 mode 2 trigger", starts - s0, 1);

    // R11: invalid config blocks start, request kept
    cfg(2'd1, 1, 6, 3, 1'b1);
    chk(cfg_err_o == 1'b1, "R11 error flag", cfg_err_o, 1);
    s0 = starts;
    request();
    te_pulse(8, 1'b1);
    repeat (3) te_pulse(4, 1'b1);
    chk(starts == s0, "R11 no start while error", starts - s0, 0);
    cfg(2'd1, 3, 6, 3, 1'b1);
    te_pulse(8, 1'b1);
    repeat (3) te_pulse(4, 1'b1);
    chk(starts == s0 + 1, "R11 held request fires", starts - s0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule